// File: doc/BRIEF.md
# Core Run Control and Exception Entry Unit

This unit holds the small control register set that belongs to one processor core: a run/status word, a protection word, a four-lane exception vector, a four-lane saved instruction register, a bank-select word and a row of module-select words. Any core in the system may access the set through a word-addressed register port. Each access carries the writing core's identifier, so the unit can tell the owning core from foreign ones. The unit also watches the owning core's current 64-bit instruction register, whose lane X (bits 15:0) is the program counter, together with a few event strobes from the core's decoder.

Setting the run bit starts the core. The unit copies the saved instruction register out to the core with a load strobe, and from that point it enforces the protection settings that were pending at the start. On an exception it swaps the instruction register with the exception vector, keeps the old value, and re-arms the vector so that it points at itself. If the vector it has just used points into the control block, the unit halts the core.

Top module: `core_guard_ctrl`

## Requirements
- R1: The run bit sits at register offset 0, bit 0. Writing 1 while halted sets it. Writing 0 never clears it. `running_o` falls only in a cycle where `halt_o` pulses.
- R2: A write of 1 to bit 0 at offset 0 while halted starts the core. One cycle later `running_o`=1, `ri_load_o`=1, and `ri_o` equals the saved instruction register (offsets 12..15, lane X at 12).
- R3: When an exception fires, the next cycle shows `ri_load_o`=1 with `ri_o` equal to the exception vector (offsets 8..11, lane X at 8). Offsets 12..15 then hold `ri_i` as it was in the exception cycle.
- R4: After an exception, offsets 8..11 read 0x0308, 0, 0, 0, and bit 8 of the protection word (offset 2) reads 0.
- R5: If lane X of the vector in use is within 0x0300..0x031F, the next cycle shows `halt_o`=1 and `running_o`=0.
- R6: While running with latched protection bit 6 set, writes to offsets 8..15 from a core whose ID differs from `CORE_ID` are ignored. While halted, such writes are accepted.
- R7: While running with latched bit 7 set, foreign writes to the bank word (offsets 17/18) and to the module-select words (offsets 25..31) are ignored. Foreign writes to the protection word are always ignored while running.
- R8: The bank word reads the same at offsets 17 and 18, and a write to either offset updates both.
- R9: While running, latched bits 8, 9 and 10 each raise an exception when the PC lies in the matching region: private 0x0040..0x02FF, volatile private 0x0800..0x0FFF, shared 0x1000..0x2FFF.
- R10: While running, latched bit 12 turns `halt_evt_i` or `illegal_evt_i` into an exception, and bit 13 does the same for `sleep_evt_i`. With bit 12 clear, `halt_evt_i` halts the core (`halt_o` pulse) and `illegal_evt_i` has no effect.
- R11: The protection word takes effect only when latched at a start. Changes made after the start, and any setting at all while halted, raise no exception.
- R12: When `exc_req_i` arrives together with a start or a register write, the exception wins. The start is dropped and the write is lost.
- R13: After reset the status reads 0, offsets 1 and 24 read `CORE_ID`, the vector reads 0x0308, 0, 0, 0, and all other words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 5 | Word offset inside the control block |
| reg_we_i | input | 1 | Write strobe |
| reg_wdata_i | input | 16 | Write data |
| reg_core_i | input | 2 | ID of the core performing the write |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i` (combinational) |
| exc_req_i | input | 1 | External exception request |
| halt_evt_i | input | 1 | Core executed a halt |
| sleep_evt_i | input | 1 | Core executed a sleep |
| illegal_evt_i | input | 1 | Core met an invalid instruction |
| ri_i | input | 64 | Current instruction register, PC in bits 15:0 |
| ri_o | output | 64 | Instruction register value to load |
| ri_load_o | output | 1 | One-cycle strobe: load `ri_o` into the core |
| halt_o | output | 1 | One-cycle halt request |
| running_o | output | 1 | Run state |

## Verification
The bench uses the defaults: `CORE_ID`=1 with a 2-bit writer ID, seven module-select words, the control block at 0x0300 and the three region windows given above. With the writer ID driven to 1 or 2, owner and foreign writes can both be tested against bits 6 and 7. The vector can be aimed into the block or away from it, so the halting and non-halting exits are both reachable. The PC can be placed in each of the three windows and in the gaps between them. A cycle model in the bench is compared with every output on every clock, so same-cycle collisions between exception, start and register write are covered.

// File: rtl/core_guard_pkg.sv
package core_guard_pkg;
  localparam int unsigned WORD_W = 16;
  localparam int unsigned LANES  = 4;
  localparam int unsigned OFFS_W = 5;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [OFFS_W-1:0] offs_t;

  localparam offs_t OFF_STATUS = 5'd0;
  localparam offs_t OFF_ID_A   = 5'd1;
  localparam offs_t OFF_PROT   = 5'd2;
  localparam offs_t OFF_VEC    = 5'd8;
  localparam offs_t OFF_SAVE   = 5'd12;
  localparam offs_t OFF_BANK_A = 5'd17;
  localparam offs_t OFF_BANK_B = 5'd18;
  localparam offs_t OFF_ID_B   = 5'd24;
  localparam offs_t OFF_MSEL   = 5'd25;

  localparam int unsigned PB_FOREIGN_EXC = 6;
  localparam int unsigned PB_FOREIGN_CFG = 7;
  localparam int unsigned PB_PC_PRIV     = 8;
  localparam int unsigned PB_PC_VPRIV    = 9;
  localparam int unsigned PB_PC_SHR      = 10;
  localparam int unsigned PB_HALT_ILL    = 12;
  localparam int unsigned PB_SLEEP       = 13;

  typedef struct packed {
    logic priv;
    logic vpriv;
    logic shr;
    logic blk;
  } region_t;
endpackage

// File: rtl/core_guard_region.sv
module core_guard_region
  import core_guard_pkg::*;
#(
  parameter word_t PRIV_LO  = 16'h0040,
  parameter word_t PRIV_HI  = 16'h02FF,
  parameter word_t VPRIV_LO = 16'h0800,
  parameter word_t VPRIV_HI = 16'h0FFF,
  parameter word_t SHR_LO   = 16'h1000,
  parameter word_t SHR_HI   = 16'h2FFF,
  parameter word_t BLK_BASE = 16'h0300
) (
  input  word_t   addr_i,
  output region_t region_o
);
  localparam word_t BLK_HI = BLK_BASE + word_t'((1 << OFFS_W) - 1);

  always_comb begin
    region_o.priv  = (addr_i >= PRIV_LO)  && (addr_i <= PRIV_HI);
    region_o.vpriv = (addr_i >= VPRIV_LO) && (addr_i <= VPRIV_HI);
    region_o.shr   = (addr_i >= SHR_LO)   && (addr_i <= SHR_HI);
    region_o.blk   = (addr_i >= BLK_BASE) && (addr_i <= BLK_HI);
  end
endmodule

// File: rtl/core_guard_wguard.sv
module core_guard_wguard
  import core_guard_pkg::*;
#(
  parameter int unsigned NUM_MSEL = 7
) (
  input  offs_t             addr_i,
  input  logic              we_i,
  input  logic              set_run_i,
  input  logic              foreign_i,
  input  logic              run_i,
  input  word_t             pact_i,
  input  logic              exc_i,
  output logic              start_o,
  output logic              we_prot_o,
  output logic [LANES-1:0]  we_vec_o,
  output logic [LANES-1:0]  we_sav_o,
  output logic              we_bank_o,
  output logic [NUM_MSEL-1:0] we_msel_o
);
  logic wr_ok, lock_exc, lock_cfg;

  // exception cycle discards every register write
  assign wr_ok    = we_i && !exc_i;
  assign lock_exc = run_i && foreign_i && pact_i[PB_FOREIGN_EXC];
  assign lock_cfg = run_i && foreign_i && pact_i[PB_FOREIGN_CFG];

  assign start_o   = wr_ok && (addr_i == OFF_STATUS) && set_run_i && !run_i;
  assign we_prot_o = wr_ok && (addr_i == OFF_PROT) && !(run_i && foreign_i);
  assign we_bank_o = wr_ok && !lock_cfg &&
                     ((addr_i == OFF_BANK_A) || (addr_i == OFF_BANK_B));

  for (genvar l = 0; l < LANES; l++) begin : g_lane_we
    assign we_vec_o[l] = wr_ok && !lock_exc && (addr_i == OFF_VEC  + offs_t'(l));
    assign we_sav_o[l] = wr_ok && !lock_exc && (addr_i == OFF_SAVE + offs_t'(l));
  end

  for (genvar m = 0; m < NUM_MSEL; m++) begin : g_msel_we
    assign we_msel_o[m] = wr_ok && !lock_cfg && (addr_i == OFF_MSEL + offs_t'(m));
  end
endmodule

// File: rtl/core_guard_seq.sv
module core_guard_seq
  import core_guard_pkg::*;
#(
  parameter int unsigned RI_W = WORD_W * LANES
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            exc_i,
  input  logic            start_i,
  input  logic            halt_plain_i,
  input  logic            vec_blk_i,
  input  logic [RI_W-1:0] vec_i,
  input  logic [RI_W-1:0] sav_i,
  output logic            run_o,
  output logic [RI_W-1:0] ri_o,
  output logic            load_o,
  output logic            halt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_o  <= 1'b0;
      ri_o   <= '0;
      load_o <= 1'b0;
      halt_o <= 1'b0;
    end else begin
      load_o <= 1'b0;
      halt_o <= 1'b0;
      if (exc_i) begin
        ri_o   <= vec_i;
        load_o <= 1'b1;
        if (vec_blk_i) begin
          run_o  <= 1'b0;
          halt_o <= 1'b1;
        end
      end else if (start_i) begin
        run_o  <= 1'b1;
        ri_o   <= sav_i;
        load_o <= 1'b1;
      end else if (halt_plain_i) begin
        run_o  <= 1'b0;
        halt_o <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/core_guard_ctrl.sv
module core_guard_ctrl
  import core_guard_pkg::*;
#(
  parameter int unsigned CORE_ID_W = 2,
  parameter int unsigned CORE_ID   = 1,
  parameter int unsigned NUM_MSEL  = 7,
  parameter word_t       BLK_BASE  = 16'h0300,
  parameter word_t       PRIV_LO   = 16'h0040,
  parameter word_t       PRIV_HI   = 16'h02FF,
  parameter word_t       VPRIV_LO  = 16'h0800,
  parameter word_t       VPRIV_HI  = 16'h0FFF,
  parameter word_t       SHR_LO    = 16'h1000,
  parameter word_t       SHR_HI    = 16'h2FFF
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [OFFS_W-1:0]    reg_addr_i,
  input  logic                 reg_we_i,
  input  logic [WORD_W-1:0]    reg_wdata_i,
  input  logic [CORE_ID_W-1:0] reg_core_i,
  output logic [WORD_W-1:0]    reg_rdata_o,
  input  logic                 exc_req_i,
  input  logic                 halt_evt_i,
  input  logic                 sleep_evt_i,
  input  logic                 illegal_evt_i,
  input  logic [WORD_W*LANES-1:0] ri_i,
  output logic [WORD_W*LANES-1:0] ri_o,
  output logic                 ri_load_o,
  output logic                 halt_o,
  output logic                 running_o
);
  localparam int unsigned RI_W   = WORD_W * LANES;
  localparam word_t       REARM_X = BLK_BASE + word_t'(OFF_VEC);
  localparam word_t       ID_WORD = word_t'(CORE_ID);

  word_t                 prot_q, pact_q, bank_q;
  word_t [LANES-1:0]     vec_q, sav_q, ri_lane;
  word_t [NUM_MSEL-1:0]  msel_q;
  region_t               pc_reg, vec_reg;
  logic                  foreign, exc_fire, int_exc, start, halt_plain;
  logic                  we_prot, we_bank;
  logic [LANES-1:0]      we_vec, we_sav;
  logic [NUM_MSEL-1:0]   we_msel;

  assign ri_lane = ri_i;
  assign foreign = (reg_core_i != CORE_ID_W'(CORE_ID));

  core_guard_region #(
    .PRIV_LO(PRIV_LO), .PRIV_HI(PRIV_HI), .VPRIV_LO(VPRIV_LO), .VPRIV_HI(VPRIV_HI),
    .SHR_LO(SHR_LO), .SHR_HI(SHR_HI), .BLK_BASE(BLK_BASE)
  ) u_pc_region (
    .addr_i  (ri_lane[0]),
    .region_o(pc_reg)
  );

  core_guard_region #(
    .PRIV_LO(PRIV_LO), .PRIV_HI(PRIV_HI), .VPRIV_LO(VPRIV_LO), .VPRIV_HI(VPRIV_HI),
    .SHR_LO(SHR_LO), .SHR_HI(SHR_HI), .BLK_BASE(BLK_BASE)
  ) u_vec_region (
    .addr_i  (vec_q[0]),
    .region_o(vec_reg)
  );

  // protection acts only through the copy latched at start, and only while running
  always_comb begin
    int_exc = (pact_q[PB_PC_PRIV]  && pc_reg.priv)  ||
              (pact_q[PB_PC_VPRIV] && pc_reg.vpriv) ||
              (pact_q[PB_PC_SHR]   && pc_reg.shr)   ||
              (pact_q[PB_HALT_ILL] && (halt_evt_i || illegal_evt_i)) ||
              (pact_q[PB_SLEEP]    && sleep_evt_i);
    exc_fire   = exc_req_i || (running_o && int_exc);
    halt_plain = running_o && halt_evt_i && !pact_q[PB_HALT_ILL];
  end

  core_guard_wguard #(.NUM_MSEL(NUM_MSEL)) u_wguard (
    .addr_i   (reg_addr_i),
    .we_i     (reg_we_i),
    .set_run_i(reg_wdata_i[0]),
    .foreign_i(foreign),
    .run_i    (running_o),
    .pact_i   (pact_q),
    .exc_i    (exc_fire),
    .start_o  (start),
    .we_prot_o(we_prot),
    .we_vec_o (we_vec),
    .we_sav_o (we_sav),
    .we_bank_o(we_bank),
    .we_msel_o(we_msel)
  );

  core_guard_seq #(.RI_W(RI_W)) u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .exc_i       (exc_fire),
    .start_i     (start),
    .halt_plain_i(halt_plain),
    .vec_blk_i   (vec_reg.blk),
    .vec_i       (vec_q),
    .sav_i       (sav_q),
    .run_o       (running_o),
    .ri_o        (ri_o),
    .load_o      (ri_load_o),
    .halt_o      (halt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prot_q <= '0;
      pact_q <= '0;
    end else if (exc_fire) begin
      prot_q[PB_PC_PRIV] <= 1'b0;
      pact_q[PB_PC_PRIV] <= 1'b0;
    end else begin
      if (we_prot) prot_q <= reg_wdata_i;
      if (start)   pact_q <= prot_q;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vec_q[l] <= (l == 0) ? REARM_X : '0;
        sav_q[l] <= '0;
      end else if (exc_fire) begin
        vec_q[l] <= (l == 0) ? REARM_X : '0;
        sav_q[l] <= ri_lane[l];
      end else begin
        if (we_vec[l]) vec_q[l] <= reg_wdata_i;
        if (we_sav[l]) sav_q[l] <= reg_wdata_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      bank_q <= '0;
    else if (we_bank) bank_q <= reg_wdata_i;
  end

  for (genvar m = 0; m < NUM_MSEL; m++) begin : g_msel
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)         msel_q[m] <= '0;
      else if (we_msel[m]) msel_q[m] <= reg_wdata_i;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      OFF_STATUS:             reg_rdata_o = {{(WORD_W-1){1'b0}}, running_o};
      OFF_ID_A, OFF_ID_B:     reg_rdata_o = ID_WORD;
      OFF_PROT:               reg_rdata_o = prot_q;
      OFF_BANK_A, OFF_BANK_B: reg_rdata_o = bank_q;
      default: begin
        if (reg_addr_i >= OFF_VEC && reg_addr_i < OFF_VEC + offs_t'(LANES))
          reg_rdata_o = vec_q[reg_addr_i[1:0]];
        else if (reg_addr_i >= OFF_SAVE && reg_addr_i < OFF_SAVE + offs_t'(LANES))
          reg_rdata_o = sav_q[reg_addr_i[1:0]];
        else if (32'(reg_addr_i) >= 32'(OFF_MSEL) &&
                 32'(reg_addr_i) <  32'(OFF_MSEL) + NUM_MSEL)
          reg_rdata_o = msel_q[32'(reg_addr_i) - 32'(OFF_MSEL)];
      end
    endcase
  end
endmodule

// File: rtl/core_guard_chk.sv
module core_guard_chk
  import core_guard_pkg::*;
#(
  parameter int unsigned CORE_ID = 1,
  parameter word_t       REARM_X = 16'h0308
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    running_o,
  input logic                    halt_o,
  input logic                    ri_load_o,
  input logic                    exc_fire,
  input logic                    exc_req_i,
  input logic [WORD_W*LANES-1:0] vec_flat,
  input word_t                   pact,
  input logic                    reg_we_i,
  input offs_t                   reg_addr_i,
  input logic                    foreign,
  input region_t                 pc_reg
);
  // R1
  a_r1_fall_needs_halt: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(running_o) |-> halt_o);
  // R2
  a_r2_start_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(running_o) |-> ri_load_o);
  // R3
  a_r3_exc_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_fire |=> ri_load_o);
  // R4
  a_r4_vec_rearmed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_fire |=> (vec_flat[WORD_W-1:0] == REARM_X));
  // R5
  a_r5_halt_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_o |-> !running_o);
  // R6
  a_r6_vec_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_i && foreign && running_o && pact[PB_FOREIGN_EXC] && !exc_fire &&
     reg_addr_i >= OFF_VEC && reg_addr_i < OFF_VEC + offs_t'(LANES))
    |=> $stable(vec_flat));
  // R9
  a_r9_regions_disjoint: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({pc_reg.priv, pc_reg.vpriv, pc_reg.shr, pc_reg.blk}));
  // R11
  a_r11_halted_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!running_o && !exc_req_i) |-> !exc_fire);
endmodule

bind core_guard_ctrl core_guard_chk #(
  .CORE_ID(CORE_ID),
  .REARM_X(REARM_X)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .running_o (running_o),
  .halt_o    (halt_o),
  .ri_load_o (ri_load_o),
  .exc_fire  (exc_fire),
  .exc_req_i (exc_req_i),
  .vec_flat  (vec_q),
  .pact      (pact_q),
  .reg_we_i  (reg_we_i),
  .reg_addr_i(reg_addr_i),
  .foreign   (foreign),
  .pc_reg    (pc_reg)
);

// File: tb/core_guard_ctrl_tb_top.sv
module core_guard_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int OWN = 1;
  localparam int OTHER = 2;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  reg_addr_i = '0;
  logic        reg_we_i = 1'b0;
  logic [15:0] reg_wdata_i = '0;
  logic [1:0]  reg_core_i = 2'(OWN);
  logic [15:0] reg_rdata_o;
  logic        exc_req_i = 1'b0, halt_evt_i = 1'b0, sleep_evt_i = 1'b0, illegal_evt_i = 1'b0;
  logic [63:0] ri_i = 64'h4444_5555_6666_0500;
  logic [63:0] ri_o;
  logic        ri_load_o, halt_o, running_o;

  int checks = 0;
  int errors = 0;

  core_guard_ctrl dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .reg_addr_i(reg_addr_i), .reg_we_i(reg_we_i),
    .reg_wdata_i(reg_wdata_i), .reg_core_i(reg_core_i), .reg_rdata_o(reg_rdata_o),
    .exc_req_i(exc_req_i), .halt_evt_i(halt_evt_i), .sleep_evt_i(sleep_evt_i),
    .illegal_evt_i(illegal_evt_i), .ri_i(ri_i), .ri_o(ri_o), .ri_load_o(ri_load_o),
    .halt_o(halt_o), .running_o(running_o)
  );

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  // behavioural model state
  bit        m_run, m_load, m_halt;
  bit [15:0] m_prot, m_pact, m_bank;
  bit [15:0] m_vec[4];
  bit [15:0] m_sav[4];
  bit [15:0] m_msel[7];
  bit [63:0] m_rio;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic bit [15:0] mread(int a);
    if (a == 0) return {15'd0, m_run};
    if (a == 1 || a == 24) return 16'(OWN);
    if (a == 2) return m_prot;
    if (a >= 8 && a < 12) return m_vec[a-8];
    if (a >= 12 && a < 16) return m_sav[a-12];
    if (a == 17 || a == 18) return m_bank;
    if (a >= 25 && a < 32) return m_msel[a-25];
    return 16'h0;
  endfunction

  function automatic bit in_rng(int v, int lo, int hi);
    return v >= lo && v <= hi;
  endfunction

  task automatic model_reset();
    m_run = 0; m_load = 0; m_halt = 0; m_prot = 0; m_pact = 0; m_bank = 0; m_rio = 0;
    foreach (m_vec[i]) m_vec[i] = 0;
    m_vec[0] = 16'h0308;
    foreach (m_sav[i]) m_sav[i] = 0;
    foreach (m_msel[i]) m_msel[i] = 0;
  endtask

  task automatic model_step();
    int pc = int'(ri_i[15:0]);
    int a = int'(reg_addr_i);
    bit foreign = (int'(reg_core_i) != OWN);
    bit cause = (m_pact[8] && in_rng(pc, 'h40, 'h2FF)) ||
                (m_pact[9] && in_rng(pc, 'h800, 'hFFF)) ||
                (m_pact[10] && in_rng(pc, 'h1000, 'h2FFF)) ||
                (m_pact[12] && (halt_evt_i || illegal_evt_i)) ||
                (m_pact[13] && sleep_evt_i);
    bit exc = exc_req_i || (m_run && cause);
    bit run0 = m_run;
    bit [15:0] pact0 = m_pact;
    m_load = 0; m_halt = 0;
    if (exc) begin
      m_rio = {m_vec[3], m_vec[2], m_vec[1], m_vec[0]};
      m_load = 1;
      if (in_rng(int'(m_vec[0]), 'h300, 'h31F)) begin m_run = 0; m_halt = 1; end
      for (int i = 0; i < 4; i++) m_sav[i] = ri_i[16*i +: 16];
      m_vec[0] = 16'h0308; m_vec[1] = 0; m_vec[2] = 0; m_vec[3] = 0;
      m_prot[8] = 0; m_pact[8] = 0;
    end else begin
      if (reg_we_i && a == 0 && reg_wdata_i[0] && !run0) begin
        m_run = 1; m_rio = {m_sav[3], m_sav[2], m_sav[1], m_sav[0]}; m_load = 1;
        m_pact = m_prot;
      end else if (run0 && halt_evt_i && !pact0[12]) begin
        m_run = 0; m_halt = 1;
      end
      if (reg_we_i) begin
        bit lk6 = run0 && foreign && pact0[6];
        bit lk7 = run0 && foreign && pact0[7];
        if (a == 2 && !(run0 && foreign)) m_prot = reg_wdata_i;
        if (a >= 8 && a < 12 && !lk6) m_vec[a-8] = reg_wdata_i;
        if (a >= 12 && a < 16 && !lk6) m_sav[a-12] = reg_wdata_i;
        if ((a == 17 || a == 18) && !lk7) m_bank = reg_wdata_i;
        if (a >= 25 && a < 32 && !lk7) m_msel[a-25] = reg_wdata_i;
      end
    end
  endtask

  // one clock: model update, edge, compare everything
  task automatic step();
    model_step();
    @(posedge clk_i);
    #1;
    chk("R1 running_o", 64'(running_o), 64'(m_run));
    chk("R2 ri_load_o", 64'(ri_load_o), 64'(m_load));
    chk("R3 ri_o", ri_o, m_rio);
    chk("R5 halt_o", 64'(halt_o), 64'(m_halt));
    chk("R13 reg_rdata_o", 64'(reg_rdata_o), 64'(mread(int'(reg_addr_i))));
  endtask

  task automatic idle();
    reg_we_i = 0; exc_req_i = 0; halt_evt_i = 0; sleep_evt_i = 0; illegal_evt_i = 0;
    reg_core_i = 2'(OWN);
  endtask

  task automatic wr(int core, int a, int d);
    reg_core_i = 2'(core); reg_addr_i = 5'(a); reg_wdata_i = 16'(d); reg_we_i = 1;
    step();
    idle();
  endtask

  task automatic rd(string tag, int a, int exp);
    reg_addr_i = 5'(a);
    step();
    chk(tag, 64'(reg_rdata_o), 64'(exp));
  endtask

  task automatic set_pc(int pc);
    ri_i[15:0] = 16'(pc);
  endtask

  task automatic pulse_evt(int which);
    case (which)
      0: exc_req_i = 1;
      1: halt_evt_i = 1;
      2: sleep_evt_i = 1;
      default: illegal_evt_i = 1;
    endcase
    step();
    idle();
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    checks++; errors++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_reset();
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1;
    // R13 reset state
    rd("R13 status", 0, 0);
    rd("R13 id lo", 1, OWN);
    rd("R13 id hi", 24, OWN);
    rd("R13 vector x", 8, 'h0308);
    rd("R13 msel", 27, 0);
    // load saved RI, vector, protection (bits 6,7,8)
    wr(OWN, 12, 'h0040); wr(OWN, 13, 'h1111); wr(OWN, 14, 'h2222); wr(OWN, 15, 'h3333);
    wr(OWN, 8, 'h0800); wr(OWN, 9, 'h000A); wr(OWN, 10, 'h000B); wr(OWN, 11, 'h000C);
    wr(OWN, 2, 'h01C0);
    // R2 start
    wr(OWN, 0, 1);
    chk("R2 start strobe", 64'(ri_load_o), 1);
    chk("R2 start ri", ri_o, 64'h3333_2222_1111_0040);
    chk("R2 running", 64'(running_o), 1);
    // R1 zero write does not clear
    wr(OWN, 0, 0);
    rd("R1 run kept", 0, 1);
    // R6 foreign writes to vector / saved blocked
    wr(OTHER, 8, 'h9999);
    rd("R6 vec foreign", 8, 'h0800);
    wr(OTHER, 13, 'h7777);
    rd("R6 sav foreign", 13, 'h1111);
    wr(OWN, 9, 'h00AA);
    rd("R6 vec own", 9, 'h00AA);
    // R7 / R8
    wr(OTHER, 17, 5);
    rd("R7 bank foreign", 18, 0);
    wr(OWN, 18, 5);
    rd("R8 bank mirror", 17, 5);
    wr(OTHER, 25, 3);
    rd("R7 msel foreign", 25, 0);
    wr(OTHER, 2, 0);
    rd("R7 prot foreign", 2, 'h01C0);
    // R11 late protection change not applied
    wr(OWN, 2, 'h3F00);
    set_pc('h0900);
    step();
    chk("R11 no exc from unlatched bit", 64'(ri_load_o), 0);
    // R9 private region exception, R3/R4
    set_pc('h0100);
    step();
    chk("R9 private exc", 64'(ri_load_o), 1);
    chk("R3 vector to ri", ri_o, 64'h000C_000B_00AA_0800);
    set_pc('h0500);
    rd("R3 saved pc", 12, 'h0100);
    rd("R3 saved w", 15, 'h4444);
    rd("R4 rearm x", 8, 'h0308);
    rd("R4 rearm y", 9, 0);
    rd("R4 prot bit8", 2, 'h3E00);
    // R5 self-pointing vector halts
    pulse_evt(0);
    chk("R5 halt", 64'(halt_o), 1);
    chk("R5 stopped", 64'(running_o), 0);
    chk("R5 ri", ri_o, 64'h0000_0000_0000_0308);
    // R11 halted: no region exceptions
    set_pc('h1200);
    step();
    chk("R11 halted quiet", 64'(ri_load_o), 0);
    set_pc('h0500);
    // R6 halted: foreign write accepted
    wr(OTHER, 8, 'h0600);
    rd("R6 halted foreign", 8, 'h0600);
    // restart, latch 0x3E00
    wr(OWN, 0, 1);
    chk("R2 restart ri", ri_o, 64'h4444_5555_6666_0500);
    set_pc('h1200);
    step();
    chk("R9 shared exc", ri_o, 64'h0000_0000_0000_0600);
    chk("R9 keeps running", 64'(running_o), 1);
    set_pc('h0500);
    wr(OWN, 8, 'h0600);
    pulse_evt(2);
    chk("R10 sleep exc", 64'(ri_load_o), 1);
    wr(OWN, 8, 'h0600);
    pulse_evt(3);
    chk("R10 illegal exc", 64'(ri_load_o), 1);
    wr(OWN, 8, 'h0600);
    pulse_evt(1);
    chk("R10 halt exc", 64'(ri_load_o), 1);
    chk("R10 halt exc no stop", 64'(running_o), 1);
    wr(OWN, 8, 'h0600);
    set_pc('h0900);
    step();
    chk("R9 volatile exc", 64'(ri_load_o), 1);
    set_pc('h0500);
    // clear protection, halt through rearmed vector, restart with none latched
    wr(OWN, 2, 0);
    pulse_evt(0);
    chk("R5 halt again", 64'(running_o), 0);
    wr(OWN, 0, 1);
    pulse_evt(1);
    chk("R10 plain halt", 64'(halt_o), 1);
    chk("R10 plain halt stop", 64'(running_o), 0);
    wr(OWN, 0, 1);
    pulse_evt(3);
    chk("R10 illegal ignored", 64'(ri_load_o), 0);
    chk("R10 illegal still running", 64'(running_o), 1);
    pulse_evt(1);
    // R12 exception beats start and writes
    wr(OWN, 8, 'h0600);
    exc_req_i = 1;
    wr(OWN, 0, 1);
    chk("R12 start dropped", 64'(running_o), 0);
    chk("R12 exc ri", ri_o, 64'h0000_0000_0000_0600);
    exc_req_i = 1;
    wr(OWN, 17, 'h77);
    rd("R12 write lost", 17, 5);
    repeat (3) step();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule